// File: doc/BRIEF.md
# Dual 8-bit GPIO Port with Register Window

This block provides two general-purpose ports, A and B, each eight bits wide, reached through an eight-location register window on an 8-bit processor bus. An external address decoder asserts the window select. The low address bits then choose one of three register kinds for either port: the synchronised pin levels (read-only), the per-bit direction, and the output data latch. Each pad is presented as three separate vectors: pad input, pad output and output enable. An I/O ring or a pad wrapper combines these into the real bidirectional pins.

Bus transfers are framed by an enable strobe `e_i`, which is sampled in the block clock domain. While `e_i` is high, the block captures the select, the read/write line, the address and the write data. The write is applied on the clock edge where `e_i` is first seen low. Reads are combinational from the current register state and pass through the window only while it is selected for a read.

Top module: `dual_gpio_port`

## Requirements
- R1: After reset, both direction registers and both output latches are 0x00, so every `*_oe_o` and `*_out_o` bit is low.
- R2: A write is applied only at the clock edge where `e_i` is first sampled low after being high. It uses the select, read/write, address and data captured while `e_i` was high. Before that edge the register keeps its old value.
- R3: Offsets 4 and 5 hold the direction of port A and port B. Bit value 1 makes that pin an output and 0 makes it an input. Each bit drives the matching output-enable bit, and a read returns the stored value.
- R4: Offsets 6 and 7 hold the output latches of port A and port B. They drive `pa_out_o` and `pb_out_o`, and a read returns the latch.
- R5: Offsets 2 and 3 read the pin levels of port A and port B. An input bit returns the pad level after a two-flop synchronizer, so a change appears in a read after the second rising clock edge. An output bit returns the latched value being driven.
- R6: Offsets 0 and 1 read as 0x00. Writes to offsets 0, 1, 2 and 3 change no register.
- R7: No register changes when the captured select is low or the captured read/write line is high (read).
- R8: `rdata_o` is 0x00 unless `cs_i` is high and `rw_i` is high.
- R9: Writing 0xFF to a direction register makes all eight pins of that port outputs, and each pin read bit then equals the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Register window select from the address decoder |
| rw_i | input | 1 | 1 = read, 0 = write |
| e_i | input | 1 | Bus enable strobe; a write is applied after its falling edge |
| addr_i | input | 3 | Register offset inside the window |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0x00 when the window is not selected for a read |
| pa_in_i | input | 8 | Port A pad input levels |
| pa_out_o | output | 8 | Port A pad output values |
| pa_oe_o | output | 8 | Port A pad output enables |
| pb_in_i | input | 8 | Port B pad input levels |
| pb_out_o | output | 8 | Port B pad output values |
| pb_oe_o | output | 8 | Port B pad output enables |

## Verification
The bench builds the block with its default widths: 8-bit data, a 3-bit offset and two synchronizer stages. With these values every one of the eight offsets, the undefined ones included, can be reached by random addresses, and the full 0x00 to 0xFF range of each register is exercised. The two-stage synchronizer keeps the pin-read latency at exactly two edges, which a directed case checks one edge at a time. Random mixes of direction bits show that input and output bits are merged per bit in the pin reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int DATA_W   = 8;
  localparam int N_PORTS  = 2;
  localparam int OFF_PIN  = 2;
  localparam int OFF_DIR  = 4;
  localparam int OFF_OUT  = 6;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bus_if.sv
module gpio_bus_if #(
  parameter int ADDR_W = 3,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rw_i,
  input  logic              e_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DW-1:0]     wdata_o
);
  logic              e_q, cs_q, rw_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e_q    <= 1'b0;
      cs_q   <= 1'b0;
      rw_q   <= 1'b1;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      e_q <= e_i;
      if (e_i) begin
        cs_q   <= cs_i;
        rw_q   <= rw_i;
        addr_q <= addr_i;
        data_q <= wdata_i;
      end
    end
  end

  // falling edge of the strobe with a selected write cycle captured
  assign commit_o = e_q && !e_i && cs_q && !rw_q;
  assign addr_o   = addr_q;
  assign wdata_o  = data_q;

  p_commit_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  p_commit_needs_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !e_i);
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_dir_i,
  input  logic         wr_out_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] pad_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] pin_o
);
  logic [W-1:0] dir_q, out_q, pad_sync;

  gpio_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .q_o   (pad_sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= '0;
      out_q <= '0;
    end else begin
      if (wr_dir_i) dir_q <= wdata_i;
      if (wr_out_i) out_q <= wdata_i;
    end
  end

  assign dir_o = dir_q;
  assign out_o = out_q;
  assign pin_o = (dir_q & out_q) | (~dir_q & pad_sync);

  p_dir_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_q));
  p_out_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_out_i |=> $stable(out_q));
  p_single_target_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_dir_i && wr_out_i));
endmodule

// File: rtl/dual_gpio_port.sv
module dual_gpio_port #(
  parameter int ADDR_W = 3,
  parameter int DW     = gpio_pkg::DATA_W,
  parameter int STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rw_i,
  input  logic              e_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [DW-1:0]     pa_in_i,
  output logic [DW-1:0]     pa_out_o,
  output logic [DW-1:0]     pa_oe_o,
  input  logic [DW-1:0]     pb_in_i,
  output logic [DW-1:0]     pb_out_o,
  output logic [DW-1:0]     pb_oe_o
);
  import gpio_pkg::*;
  localparam int NP = N_PORTS;

  logic              commit;
  logic [ADDR_W-1:0] waddr;
  logic [DW-1:0]     wdata;
  logic [DW-1:0]     pad   [NP];
  logic [DW-1:0]     dir   [NP];
  logic [DW-1:0]     dout  [NP];
  logic [DW-1:0]     pin   [NP];

  gpio_bus_if #(.ADDR_W(ADDR_W), .DW(DW)) u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cs_i    (cs_i),
    .rw_i    (rw_i),
    .e_i     (e_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .commit_o(commit),
    .addr_o  (waddr),
    .wdata_o (wdata)
  );

  assign pad[0] = pa_in_i;
  assign pad[1] = pb_in_i;

  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam logic [ADDR_W-1:0] DIR_A = ADDR_W'(OFF_DIR + p);
    localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OFF_OUT + p);
    gpio_port #(.W(DW), .STAGES(STAGES)) u_port (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_dir_i(commit && (waddr == DIR_A)),
      .wr_out_i(commit && (waddr == OUT_A)),
      .wdata_i (wdata),
      .pad_i   (pad[p]),
      .dir_o   (dir[p]),
      .out_o   (dout[p]),
      .pin_o   (pin[p])
    );
  end

  assign pa_oe_o  = dir[0];
  assign pa_out_o = dout[0];
  assign pb_oe_o  = dir[1];
  assign pb_out_o = dout[1];

  always_comb begin
    rdata_o = '0;
    if (cs_i && rw_i) begin
      for (int p = 0; p < NP; p++) begin
        if (addr_i == ADDR_W'(OFF_PIN + p)) rdata_o = pin[p];
        if (addr_i == ADDR_W'(OFF_DIR + p)) rdata_o = dir[p];
        if (addr_i == ADDR_W'(OFF_OUT + p)) rdata_o = dout[p];
      end
    end
  end

  p_idle_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rw_i) |-> rdata_o == '0);
  p_undef_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rw_i && addr_i < ADDR_W'(OFF_PIN)) |-> rdata_o == '0);
  p_pin_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rw_i && addr_i == ADDR_W'(OFF_PIN)) |-> ((rdata_o & pa_oe_o) == (pa_out_o & pa_oe_o)));
  p_dir_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rw_i && addr_i == ADDR_W'(OFF_DIR + 1)) |-> rdata_o == pb_oe_o);
endmodule

// File: tb/sim_dual_gpio_port.sv
module sim_dual_gpio_port;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       cs = 1'b0, rw = 1'b1, e = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] m_dir [2];
  logic [7:0] m_out [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_gpio_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rw_i(rw), .e_i(e),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pa_in_i(pa_in), .pa_out_o(pa_out), .pa_oe_o(pa_oe),
    .pb_in_i(pb_in), .pb_out_o(pb_out), .pb_oe_o(pb_oe)
  );

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > MAX_CYCLES) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d cycles exp <= %0d", cycles, MAX_CYCLES);
      finish_run();
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act %02h exp %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd2: return (m_dir[0] & m_out[0]) | (~m_dir[0] & pa_in);
      3'd3: return (m_dir[1] & m_out[1]) | (~m_dir[1] & pb_in);
      3'd4: return m_dir[0];
      3'd5: return m_dir[1];
      3'd6: return m_out[0];
      3'd7: return m_out[1];
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(logic [2:0] a, logic [7:0] d);
    case (a)
      3'd4: m_dir[0] = d;
      3'd5: m_dir[1] = d;
      3'd6: m_out[0] = d;
      3'd7: m_out[1] = d;
      default: ;
    endcase
  endfunction

  task automatic bus_cycle(logic c, logic r, logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    cs = c; rw = r; addr = a; wdata = d; e = 1'b1;
    @(negedge clk);
    e = 1'b0;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
    if (c && !r) model_write(a, d);
  endtask

  task automatic bus_write(logic [2:0] a, logic [7:0] d);
    bus_cycle(1'b1, 1'b0, a, d);
  endtask

  task automatic bus_read(string req, logic [2:0] a);
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; addr = a; e = 1'b1;
    #1 check(req, rdata, exp_read(a));
    e = 1'b0; cs = 1'b0;
  endtask

  task automatic check_ports(string req);
    check({req, " pa_oe"}, pa_oe, m_dir[0]);
    check({req, " pb_oe"}, pb_oe, m_dir[1]);
    check({req, " pa_out"}, pa_out, m_out[0]);
    check({req, " pb_out"}, pb_out, m_out[1]);
  endtask

  initial begin
    logic [7:0] old_v;
    void'($urandom(32'd4242));
    m_dir[0] = '0; m_dir[1] = '0; m_out[0] = '0; m_out[1] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    check_ports("R1");
    for (int a = 2; a < 8; a++) bus_read("R1", 3'(a));

    // R2 nothing changes before the strobe falls
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = 3'd6; wdata = 8'hA5; e = 1'b1;
    @(negedge clk);
    check("R2 before fall", pa_out, 8'h00);
    e = 1'b0;
    @(negedge clk);
    cs = 1'b0; rw = 1'b1;
    m_out[0] = 8'hA5;
    check("R2 after fall", pa_out, 8'hA5);

    // R3, R4 direction and output latches
    bus_write(3'd4, 8'h0F);
    bus_write(3'd5, 8'hC3);
    bus_write(3'd7, 8'h5A);
    check_ports("R3 R4");
    bus_read("R3", 3'd4);
    bus_read("R3", 3'd5);
    bus_read("R4", 3'd6);
    bus_read("R4", 3'd7);

    // R9 whole port as output
    bus_write(3'd4, 8'hFF);
    pa_in = 8'h00;
    repeat (3) @(negedge clk);
    check("R9 oe", pa_oe, 8'hFF);
    bus_read("R9", 3'd2);

    // R5 synchronizer latency on an input port
    bus_write(3'd5, 8'h00);
    pb_in = 8'h00;
    repeat (3) @(negedge clk);
    pb_in = 8'h96;
    @(negedge clk);
    cs = 1'b1; rw = 1'b1; addr = 3'd3;
    #1 check("R5 one edge", rdata, 8'h00);
    @(negedge clk);
    #1 check("R5 two edges", rdata, 8'h96);
    cs = 1'b0;

    // R6 undefined and read-only offsets
    for (int a = 0; a < 4; a++) begin
      bus_write(3'(a), 8'h3C);
      check_ports("R6");
    end
    bus_read("R6", 3'd0);
    bus_read("R6", 3'd1);

    // R7 unselected or read cycles change nothing
    bus_cycle(1'b0, 1'b0, 3'd6, 8'hEE);
    bus_cycle(1'b1, 1'b1, 3'd7, 8'hEE);
    bus_cycle(1'b0, 1'b0, 3'd4, 8'h11);
    check_ports("R7");

    // R8 read data idles at zero
    @(negedge clk);
    cs = 1'b1; rw = 1'b0; addr = 3'd6;
    #1 check("R8 write phase", rdata, 8'h00);
    cs = 1'b0; rw = 1'b1;
    #1 check("R8 deselected", rdata, 8'h00);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) begin
        bus_write(3'($urandom_range(0, 7)), 8'($urandom));
        check_ports("R3 R4 random");
      end else if (op == 1) begin
        pa_in = 8'($urandom); pb_in = 8'($urandom);
        repeat (3) @(negedge clk);
      end else begin
        old_v = 8'($urandom_range(0, 7));
        bus_read("R5 R6 random", old_v[2:0]);
      end
    end

    finish_run();
  end
endmodule